// File: doc/BRIEF.md
# Host-Shared Command and Completion Ring Controller

This block is the controller-side end of two circular queues whose producer and consumer sit on opposite sides of an interconnect. Commands flow from host to controller. The host stores fixed-size command entries straight into the controller's command ring with posted writes, then publishes its new tail index. The controller hands entries out in ring order on a valid/ready dequeue stream and exposes its head index, so the host can see which slots are free again. Each entry is opaque: a command descriptor block plus segment pointers, passed through without decoding.

Completions flow the other way. The controller offers a completion (a command tag, a status code and a flag) on an enqueue stream. The block turns it into a DMA write request aimed at the matching slot of a completion ring in host memory. The flag marks a completion that may ride along with a read-data transfer to the host. The host publishes how far it has consumed that ring. The block stalls new completions while the ring is full, and advances its host-visible tail only once the DMA write has been accepted.

Both rings have a power-of-two depth. Empty means head equals tail, and full means tail plus one equals head, so one slot always stays unused.

Top module: `hq_ring_ctrl`

## Requirements
- R1: After reset, cmd_valid, dma_req_valid, cmd_head_o and cpl_tail_o are all zero, and cpl_ready is one.
- R2: A host write with host_wr_sel=0 stores host_wr_data into command slot host_wr_idx. A host write with host_wr_sel=1 publishes the command tail from host_wr_data[IDX_W-1:0]. Published entries appear on cmd_data in ring order, with their slot index on cmd_slot. The first entry is valid after the second rising edge following the tail write.
- R3: cmd_valid stays low whenever the published command tail equals the command head. In particular, storing slots without publishing a tail never raises it.
- R4: cmd_head_o advances by exactly one, modulo DEPTH, on each cycle where cmd_valid and cmd_ready are both high, and it holds otherwise.
- R5: Both rings wrap from slot DEPTH-1 back to slot 0. The command ring accepts up to DEPTH-1 published entries.
- R6: A completion accepted on cpl_valid/cpl_ready becomes a DMA request on the next cycle. dma_req_data is {cpl_status, cpl_tag}, with the status in the upper bits, and dma_req_merge equals cpl_merge.
- R7: dma_req_addr equals CPL_BASE + slot*ELEM_BYTES. The slot starts at 0 and increments by one per accepted completion, modulo DEPTH.
- R8: cpl_ready is low while the completion ring is full, that is, while issued index plus one equals the completion head that the host published with host_wr_sel=2. After such a stall, a newer published head releases it.
- R9: A pending DMA request holds its address, data and flag while dma_req_ready is low. cpl_tail_o advances by one on each DMA handshake.
- R10: A host write with host_wr_sel=3 changes nothing: cmd_valid, cmd_head_o and cpl_ready keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host posted-write strobe |
| host_wr_sel | input | 2 | 0 slot store, 1 command tail, 2 completion head, 3 no target |
| host_wr_idx | input | IDX_W | Command slot written when host_wr_sel=0 |
| host_wr_data | input | CMD_W | Entry or pointer value |
| cmd_head_o | output | IDX_W | Command head index, readable by the host |
| cmd_valid | output | 1 | Command entry available |
| cmd_ready | input | 1 | Command consumer accepts |
| cmd_data | output | CMD_W | Command entry |
| cmd_slot | output | IDX_W | Slot index of the presented entry |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion accepted this cycle |
| cpl_tag | input | TAG_W | Reference to the answered command |
| cpl_status | input | STAT_W | Status code |
| cpl_merge | input | 1 | Completion may ride with read data |
| cpl_tail_o | output | IDX_W | Completion tail, visible to the host |
| dma_req_valid | output | 1 | DMA write request pending |
| dma_req_ready | input | 1 | DMA engine accepts the request |
| dma_req_addr | output | ADDR_W | Host address of the completion slot |
| dma_req_data | output | TAG_W+STAT_W | Completion entry |
| dma_req_merge | output | 1 | Merge hint for the DMA engine |

## Verification
The assertions assume that the host never publishes a command tail that overruns the head. In other words, the number of published but unconsumed entries stays at most DEPTH-1. They also assume that the host writes a slot before it publishes a tail that covers that slot. The stimulus keeps to this by tracking its own tail and head copies and never publishing more than DEPTH-1 outstanding entries. It also publishes completion heads only up to the completion tail it has observed, so the full and empty indications stay meaningful. Within those limits, the sweep runs a small ring through several wraps, with batches of one to DEPTH-1 entries, and fills the completion ring completely in both directions.

// File: rtl/hq_pkg.sv
package hq_pkg;

  typedef enum logic [1:0] {
    HW_SLOT     = 2'd0,
    HW_CMD_TAIL = 2'd1,
    HW_CPL_HEAD = 2'd2,
    HW_NONE     = 2'd3
  } hw_sel_e;

endpackage

// File: rtl/hq_host_port.sv
module hq_host_port
  import hq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CMD_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CMD_W-1:0] wr_data,
  output logic             slot_we,
  output logic [IDX_W-1:0] slot_idx,
  output logic [CMD_W-1:0] slot_data,
  output logic [IDX_W-1:0] cmd_tail,
  output logic [IDX_W-1:0] cpl_head
);

  hw_sel_e sel;
  logic [IDX_W-1:0] cmd_tail_q;
  logic [IDX_W-1:0] cpl_head_q;

  assign sel       = hw_sel_e'(wr_sel);
  assign slot_we   = wr_en && (sel == HW_SLOT);
  assign slot_idx  = wr_idx;
  assign slot_data = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_tail_q <= '0;
      cpl_head_q <= '0;
    end else if (wr_en) begin
      case (sel)
        HW_CMD_TAIL: cmd_tail_q <= wr_data[IDX_W-1:0];
        HW_CPL_HEAD: cpl_head_q <= wr_data[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  assign cmd_tail = cmd_tail_q;
  assign cpl_head = cpl_head_q;

endmodule

// File: rtl/hq_cmd_ring.sv
module hq_cmd_ring #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CMD_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_we,
  input  logic [IDX_W-1:0] slot_idx,
  input  logic [CMD_W-1:0] slot_data,
  input  logic [IDX_W-1:0] host_tail,
  output logic [IDX_W-1:0] head_o,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CMD_W-1:0] out_data,
  output logic [IDX_W-1:0] out_slot
);

  logic [CMD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] fetch_q;
  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] slot_q;
  logic [CMD_W-1:0] data_q;
  logic             valid_q;
  logic             take;
  logic             fetch;

  assign take  = valid_q && out_ready;
  assign fetch = (fetch_q != host_tail) && (!valid_q || out_ready);

  always_ff @(posedge clk) begin
    if (slot_we) mem[slot_idx] <= slot_data;
  end

  always_ff @(posedge clk) begin
    if (fetch) data_q <= mem[fetch_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q <= '0;
      head_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (take) head_q <= head_q + 1'b1;
      if (fetch) begin
        slot_q  <= fetch_q;
        fetch_q <= fetch_q + 1'b1;
        valid_q <= 1'b1;
      end else if (take) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign head_o    = head_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_slot  = slot_q;

endmodule

// File: rtl/hq_cpl_ring.sv
module hq_cpl_ring #(
  parameter int              DEPTH      = 16,
  parameter int              IDX_W      = 4,
  parameter int              TAG_W      = 8,
  parameter int              STAT_W     = 8,
  parameter int              ADDR_W     = 32,
  parameter int              ELEM_BYTES = 16,
  parameter logic [ADDR_W-1:0] BASE     = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        host_head,
  input  logic                    enq_valid,
  output logic                    enq_ready,
  input  logic [TAG_W-1:0]        enq_tag,
  input  logic [STAT_W-1:0]       enq_status,
  input  logic                    enq_merge,
  output logic                    dma_valid,
  input  logic                    dma_ready,
  output logic [ADDR_W-1:0]       dma_addr,
  output logic [TAG_W+STAT_W-1:0] dma_data,
  output logic                    dma_merge,
  output logic [IDX_W-1:0]        tail_o,
  output logic [IDX_W-1:0]        issue_o
);

  localparam int  ENT_W    = TAG_W + STAT_W;
  localparam bit  ELEM_P2  = (ELEM_BYTES & (ELEM_BYTES - 1)) == 0;
  localparam int  ELEM_SH  = $clog2(ELEM_BYTES);

  logic [IDX_W-1:0]  issue_q;
  logic [IDX_W-1:0]  tail_q;
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ENT_W-1:0]  data_q;
  logic              merge_q;
  logic [ADDR_W-1:0] offset;
  logic              full;
  logic              accept;

  generate
    if (ELEM_P2) begin : g_shift
      assign offset = ADDR_W'(issue_q) << ELEM_SH;
    end else begin : g_mul
      assign offset = ADDR_W'(issue_q) * ADDR_W'(ELEM_BYTES);
    end
  endgenerate

  assign full      = IDX_W'(issue_q + 1'b1) == host_head;
  assign enq_ready = !full && (!valid_q || dma_ready);
  assign accept    = enq_valid && enq_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_q <= '0;
      tail_q  <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      merge_q <= 1'b0;
    end else begin
      if (valid_q && dma_ready) tail_q <= tail_q + 1'b1;
      if (accept) begin
        issue_q <= issue_q + 1'b1;
        valid_q <= 1'b1;
        addr_q  <= BASE + offset;
        data_q  <= {enq_status, enq_tag};
        merge_q <= enq_merge;
      end else if (dma_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign dma_valid = valid_q;
  assign dma_addr  = addr_q;
  assign dma_data  = data_q;
  assign dma_merge = merge_q;
  assign tail_o    = tail_q;
  assign issue_o   = issue_q;

endmodule

// File: rtl/hq_ring_ctrl.sv
module hq_ring_ctrl #(
  parameter int                DEPTH      = 16,
  parameter int                CMD_W      = 64,
  parameter int                TAG_W      = 8,
  parameter int                STAT_W     = 8,
  parameter int                ADDR_W     = 32,
  parameter int                ELEM_BYTES = 16,
  parameter logic [ADDR_W-1:0] CPL_BASE   = 32'h1000_0000,
  localparam int               IDX_W      = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_wr_en,
  input  logic [1:0]              host_wr_sel,
  input  logic [IDX_W-1:0]        host_wr_idx,
  input  logic [CMD_W-1:0]        host_wr_data,
  output logic [IDX_W-1:0]        cmd_head_o,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [CMD_W-1:0]        cmd_data,
  output logic [IDX_W-1:0]        cmd_slot,
  input  logic                    cpl_valid,
  output logic                    cpl_ready,
  input  logic [TAG_W-1:0]        cpl_tag,
  input  logic [STAT_W-1:0]       cpl_status,
  input  logic                    cpl_merge,
  output logic [IDX_W-1:0]        cpl_tail_o,
  output logic                    dma_req_valid,
  input  logic                    dma_req_ready,
  output logic [ADDR_W-1:0]       dma_req_addr,
  output logic [TAG_W+STAT_W-1:0] dma_req_data,
  output logic                    dma_req_merge
);

  logic             slot_we;
  logic [IDX_W-1:0] slot_idx;
  logic [CMD_W-1:0] slot_data;
  logic [IDX_W-1:0] cmd_tail_q;
  logic [IDX_W-1:0] cpl_head_q;
  logic [IDX_W-1:0] cpl_issue_q;

  hq_host_port #(.IDX_W(IDX_W), .CMD_W(CMD_W)) u_host (
    .clk(clk), .rst(rst),
    .wr_en(host_wr_en), .wr_sel(host_wr_sel), .wr_idx(host_wr_idx), .wr_data(host_wr_data),
    .slot_we(slot_we), .slot_idx(slot_idx), .slot_data(slot_data),
    .cmd_tail(cmd_tail_q), .cpl_head(cpl_head_q)
  );

  hq_cmd_ring #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst(rst),
    .slot_we(slot_we), .slot_idx(slot_idx), .slot_data(slot_data),
    .host_tail(cmd_tail_q), .head_o(cmd_head_o),
    .out_valid(cmd_valid), .out_ready(cmd_ready), .out_data(cmd_data), .out_slot(cmd_slot)
  );

  hq_cpl_ring #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .STAT_W(STAT_W),
    .ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES), .BASE(CPL_BASE)
  ) u_cpl (
    .clk(clk), .rst(rst), .host_head(cpl_head_q),
    .enq_valid(cpl_valid), .enq_ready(cpl_ready), .enq_tag(cpl_tag),
    .enq_status(cpl_status), .enq_merge(cpl_merge),
    .dma_valid(dma_req_valid), .dma_ready(dma_req_ready), .dma_addr(dma_req_addr),
    .dma_data(dma_req_data), .dma_merge(dma_req_merge),
    .tail_o(cpl_tail_o), .issue_o(cpl_issue_q)
  );

endmodule

// File: rtl/hq_ring_ctrl_chk.sv
module hq_ring_ctrl_chk #(
  parameter int                DEPTH      = 16,
  parameter int                IDX_W      = 4,
  parameter int                ENT_W      = 16,
  parameter int                ADDR_W     = 32,
  parameter int                ELEM_BYTES = 16,
  parameter logic [ADDR_W-1:0] CPL_BASE   = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  cmd_head_o,
  input logic [IDX_W-1:0]  cmd_tail_q,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic [IDX_W-1:0]  cpl_head_q,
  input logic [IDX_W-1:0]  cpl_issue_q,
  input logic [IDX_W-1:0]  cpl_tail_o,
  input logic              dma_req_valid,
  input logic              dma_req_ready,
  input logic [ADDR_W-1:0] dma_req_addr,
  input logic [ENT_W-1:0]  dma_req_data
);

  localparam logic [ADDR_W:0] LIMIT = {1'b0, CPL_BASE} + (ADDR_W+1)'(DEPTH * ELEM_BYTES);

  AST_CMD_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_head_o != cmd_tail_q)); // R3

  AST_CMD_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (cmd_head_o == IDX_W'($past(cmd_head_o) + 1'b1))); // R4

  AST_CMD_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready) |=> $stable(cmd_head_o)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && cpl_ready) |-> (IDX_W'(cpl_issue_q + 1'b1) != cpl_head_q)); // R8

  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dma_req_valid && !dma_req_ready) |=>
      (dma_req_valid && $stable(dma_req_addr) && $stable(dma_req_data))); // R9

  AST_CPL_TAIL_STEP: assert property (@(posedge clk) disable iff (rst)
    (dma_req_valid && dma_req_ready) |=> (cpl_tail_o == IDX_W'($past(cpl_tail_o) + 1'b1))); // R9

  AST_DMA_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> (dma_req_addr >= CPL_BASE && {1'b0, dma_req_addr} < LIMIT)); // R7

  AST_CPL_ACCEPT_REQ: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && cpl_ready) |=> dma_req_valid); // R6

endmodule

bind hq_ring_ctrl hq_ring_ctrl_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .ENT_W(TAG_W+STAT_W), .ADDR_W(ADDR_W),
  .ELEM_BYTES(ELEM_BYTES), .CPL_BASE(CPL_BASE)
) u_chk (
  .clk(clk), .rst(rst),
  .cmd_head_o(cmd_head_o), .cmd_tail_q(cmd_tail_q),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
  .cpl_head_q(cpl_head_q), .cpl_issue_q(cpl_issue_q), .cpl_tail_o(cpl_tail_o),
  .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
  .dma_req_addr(dma_req_addr), .dma_req_data(dma_req_data)
);

// File: tb/hq_ring_ctrl_tb.sv
module hq_ring_ctrl_tb;

  localparam int          DEPTH = 4;
  localparam int          IDX_W = 2;
  localparam int          CMD_W = 64;
  localparam int          ELEM  = 16;
  localparam logic [31:0] BASE  = 32'h1000_0000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             host_wr_en = 1'b0;
  logic [1:0]       host_wr_sel = '0;
  logic [IDX_W-1:0] host_wr_idx = '0;
  logic [CMD_W-1:0] host_wr_data = '0;
  logic [IDX_W-1:0] cmd_head_o;
  logic             cmd_valid;
  logic             cmd_ready = 1'b0;
  logic [CMD_W-1:0] cmd_data;
  logic [IDX_W-1:0] cmd_slot;
  logic             cpl_valid = 1'b0;
  logic             cpl_ready;
  logic [7:0]       cpl_tag = '0;
  logic [7:0]       cpl_status = '0;
  logic             cpl_merge = 1'b0;
  logic [IDX_W-1:0] cpl_tail_o;
  logic             dma_req_valid;
  logic             dma_req_ready = 1'b0;
  logic [31:0]      dma_req_addr;
  logic [15:0]      dma_req_data;
  logic             dma_req_merge;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hq_ring_ctrl #(.DEPTH(DEPTH), .CMD_W(CMD_W), .TAG_W(8), .STAT_W(8), .ADDR_W(32),
                 .ELEM_BYTES(ELEM), .CPL_BASE(BASE)) u_dut (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_idx(host_wr_idx),
    .host_wr_data(host_wr_data),
    .cmd_head_o(cmd_head_o), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_slot(cmd_slot),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag),
    .cpl_status(cpl_status), .cpl_merge(cpl_merge), .cpl_tail_o(cpl_tail_o),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
    .dma_req_addr(dma_req_addr), .dma_req_data(dma_req_data), .dma_req_merge(dma_req_merge)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [IDX_W-1:0] idx,
                            input logic [CMD_W-1:0] data);
    host_wr_en = 1'b1; host_wr_sel = sel; host_wr_idx = idx; host_wr_data = data;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  function automatic logic [CMD_W-1:0] cmd_pat(input int round, input int k);
    return 64'hC0DE_0000_0000_0000 | (64'(round) << 16) | (64'(k) << 4) | 64'h5;
  endfunction

  int cmd_tail = 0;
  int cmd_head = 0;
  int cpl_n    = 0;
  int cpl_hd   = 0;

  task automatic enq_one(input string req);
    logic [7:0] tag, st;
    logic       mg;
    tag = 8'(cpl_n * 7 + 3);
    st  = 8'(8'hA0 + cpl_n);
    mg  = cpl_n[0];
    cpl_valid = 1'b1; cpl_tag = tag; cpl_status = st; cpl_merge = mg;
    #1;
    check(req, "cpl_ready before accept", 64'(cpl_ready), 64'd1);
    @(negedge clk);
    cpl_valid = 1'b0;
    check("R6", "dma_req_valid", 64'(dma_req_valid), 64'd1);
    check("R6", "dma_req_data", 64'(dma_req_data), 64'({st, tag}));
    check("R6", "dma_req_merge", 64'(dma_req_merge), 64'(mg));
    check("R7", "dma_req_addr", 64'(dma_req_addr), 64'(BASE + 32'((cpl_n % DEPTH) * ELEM)));
    dma_req_ready = 1'b1;
    @(negedge clk);
    dma_req_ready = 1'b0;
    cpl_n++;
    check("R9", "cpl_tail_o", 64'(cpl_tail_o), 64'(cpl_n % DEPTH));
    check("R9", "dma_req_valid after handshake", 64'(dma_req_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "cmd_valid", 64'(cmd_valid), 64'd0);
    check("R1", "dma_req_valid", 64'(dma_req_valid), 64'd0);
    check("R1", "cmd_head_o", 64'(cmd_head_o), 64'd0);
    check("R1", "cpl_tail_o", 64'(cpl_tail_o), 64'd0);
    check("R1", "cpl_ready", 64'(cpl_ready), 64'd1);

    // R3: slot stores without a tail publish keep the ring empty
    host_write(2'd0, 2'd0, cmd_pat(99, 0));
    host_write(2'd0, 2'd1, cmd_pat(99, 1));
    @(negedge clk);
    check("R3", "cmd_valid without tail", 64'(cmd_valid), 64'd0);

    // R10: a write to no target leaves state untouched
    host_write(2'd3, 2'd0, 64'd2);
    @(negedge clk);
    check("R10", "cmd_valid", 64'(cmd_valid), 64'd0);
    check("R10", "cmd_head_o", 64'(cmd_head_o), 64'd0);
    check("R10", "cpl_ready", 64'(cpl_ready), 64'd1);

    // R2/R4/R5: batches of 1..DEPTH-1 entries over several wraps
    for (int round = 0; round < 9; round++) begin
      int n;
      n = (round % (DEPTH - 1)) + 1;
      for (int k = 0; k < n; k++)
        host_write(2'd0, IDX_W'((cmd_tail + k) % DEPTH), cmd_pat(round, k));
      cmd_tail = (cmd_tail + n) % DEPTH;
      host_write(2'd1, 2'd0, 64'(cmd_tail));
      @(negedge clk);
      check("R2", "cmd_valid two edges after tail", 64'(cmd_valid), 64'd1);
      for (int k = 0; k < n; k++) begin
        check("R2", "cmd_data", cmd_data, cmd_pat(round, k));
        check("R5", "cmd_slot", 64'(cmd_slot), 64'(cmd_head));
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        cmd_head = (cmd_head + 1) % DEPTH;
        check("R4", "cmd_head_o", 64'(cmd_head_o), 64'(cmd_head));
      end
      check("R3", "cmd_valid when drained", 64'(cmd_valid), 64'd0);
      @(negedge clk);
      check("R4", "cmd_head_o holds idle", 64'(cmd_head_o), 64'(cmd_head));
    end

    // R9: request held while DMA engine stalls
    cpl_valid = 1'b1; cpl_tag = 8'h3C; cpl_status = 8'h81; cpl_merge = 1'b1;
    @(negedge clk);
    cpl_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "held valid", 64'(dma_req_valid), 64'd1);
    check("R9", "held data", 64'(dma_req_data), 64'h813C);
    check("R9", "held addr", 64'(dma_req_addr), 64'(BASE));
    check("R9", "tail before handshake", 64'(cpl_tail_o), 64'd0);
    dma_req_ready = 1'b1;
    @(negedge clk);
    dma_req_ready = 1'b0;
    cpl_n = 1;
    check("R9", "tail after handshake", 64'(cpl_tail_o), 64'd1);

    // R8: fill the completion ring, stall, release, repeat across wraps
    for (int pass = 0; pass < 3; pass++) begin
      while ((cpl_n + 1) % DEPTH != cpl_hd) enq_one("R8");
      check("R8", "cpl_ready when full", 64'(cpl_ready), 64'd0);
      cpl_valid = 1'b1;
      @(negedge clk);
      cpl_valid = 1'b0;
      check("R8", "no request when full", 64'(dma_req_valid), 64'd0);
      cpl_hd = (cpl_hd + 2) % DEPTH;
      host_write(2'd2, 2'd0, 64'(cpl_hd));
      check("R8", "cpl_ready after head publish", 64'(cpl_ready), 64'd1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule